// File: doc/BRIEF.md
# Interrupt Controller Processor Interface

This block sits between the interrupt distributor and a single processor. Each cycle the distributor presents its most urgent pending interrupt: a valid flag, a 10-bit identifier, an 8-bit priority and the 2-bit number of the processor that raised it. The block weighs that candidate against two limits. One is a programmable priority threshold. The other is the priority of the interrupt currently being serviced. If the candidate beats both limits and signalling is enabled, the block raises a registered interrupt request line toward the processor.

Software talks to the block over a simple 32-bit register bus. There is one access per cycle and read data is returned in the same cycle. A read of the claim register takes the candidate into service. The distributor is told through a one-cycle strobe so it can drop the pending state. The candidate's priority becomes the new running priority. A write to the completion register retires an interrupt that is in service. In-service interrupts are kept on a small stack of parameterised depth, so a more urgent interrupt can nest above a less urgent one. Claims made when nothing qualifies return the reserved identifier 1023.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the request line is low, the enable bit (0x00 bit 0) reads 0, the threshold (0x04 bits 7:0) reads 0x00, the running priority reads 0xFF and a claim returns 1023.
- R2: While enable bit 0x00[0] is 0, the request line stays low and a claim read returns 1023 with no claim strobe.
- R3: A candidate is signalled only if its priority value is strictly lower than the threshold. A candidate equal to the threshold is not signalled.
- R4: A candidate is signalled only if its priority value is strictly lower than the current running priority. An equal value does not preempt.
- R5: A claim read at 0x0C of a qualifying candidate returns its identifier in bits 9:0 and its source processor in bits 11:10. In the same cycle it pulses the claim strobe with that identifier. From the next cycle the running priority equals the candidate's priority.
- R6: A claim read when no candidate qualifies returns 1023 with bits 11:10 zero. It gives no claim strobe and leaves the running priority unchanged.
- R7: A write to 0x10 whose bits 9:0 name an in-service interrupt removes that interrupt from service and pulses the completion strobe in the same cycle. This holds even when the interrupt is not the innermost one. The running priority then becomes that of the innermost remaining interrupt, or 0xFF if none remains.
- R8: A completion write naming an identifier that is not in service is ignored: no completion strobe, and the running priority is unchanged.
- R9: The running-priority register at 0x14 returns the current running priority in bits 7:0.
- R10: The pending-view register at 0x18 returns the distributor's candidate identifier in bits 9:0 and its source in bits 11:10 whenever a candidate is valid, whatever the enable and threshold. It returns 1023 when no candidate is valid.
- R11: When DEPTH interrupts (4 by default) are in service, the request line stays low and claims return 1023 until one is completed.
- R12: The request line follows the qualify condition with exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | Distributor has a pending candidate |
| hp_id | input | 10 | Candidate identifier |
| hp_prio | input | 8 | Candidate priority, lower value is more urgent |
| hp_src | input | 2 | Processor that raised the candidate |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request to the processor |
| claim_stb | output | 1 | Candidate taken into service this cycle |
| claim_id | output | 10 | Identifier taken into service |
| done_stb | output | 1 | In-service interrupt retired this cycle |
| done_id | output | 10 | Identifier retired |

## Verification
A corrupted in-service stack shows up at the ports within one access, through two registers. The running-priority register would report the wrong level. The request line would then assert for a candidate that should not preempt, or stay low for one that should. An entry lost or left behind when a completion compacts the stack appears on a later completion: the completion strobe goes missing for an identifier that was claimed, or fires for one that was already retired. A miscounted stack depth appears as a claim that is wrongly refused or wrongly accepted right at the depth limit.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
  // Register word offsets (byte offset / 4); software depends on these.
  localparam int W_CTRL  = 0;  // 0x00 enable
  localparam int W_THR   = 1;  // 0x04 threshold
  localparam int W_CLAIM = 3;  // 0x0C claim (read side effect)
  localparam int W_DONE  = 4;  // 0x10 completion (write side effect)
  localparam int W_RUN   = 5;  // 0x14 running priority
  localparam int W_PEND  = 6;  // 0x18 pending view
  localparam int NONE_ID = 1023;
endpackage

// File: rtl/irq_cif_regs.sv
module irq_cif_regs
  import irq_cif_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              qualify,
  input  logic              hp_valid,
  input  logic [ID_W-1:0]   hp_id,
  input  logic [SRC_W-1:0]  hp_src,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] thr_q,
  output logic              claim_rd,
  output logic              done_wr,
  output logic [ID_W-1:0]   done_wid
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   word;
  logic              wr_ctrl, wr_thr;
  logic              en_d;
  logic [PRIO_W-1:0] thr_d;
  logic [31:0]       none_word;
  logic [31:0]       cand_word;
  logic              unused_bits;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_sel && bus_wr && (word == WA_W'(W_CTRL));
  assign wr_thr  = bus_sel && bus_wr && (word == WA_W'(W_THR));
  assign claim_rd = bus_sel && !bus_wr && (word == WA_W'(W_CLAIM));
  assign done_wr  = bus_sel && bus_wr && (word == WA_W'(W_DONE));
  assign done_wid = bus_wdata[ID_W-1:0];
  assign unused_bits = ^{bus_wdata[31:ID_W], bus_addr[1:0]};

  // Next-state for programmable registers
  always_comb begin
    en_d  = ctrl_en;
    thr_d = thr_q;
    if (wr_ctrl) en_d  = bus_wdata[0];
    if (wr_thr)  thr_d = bus_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      thr_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_en <= en_d;
      if (wr_thr)  thr_q   <= thr_d;
    end
  end

  // Read words
  always_comb begin
    none_word = '0;
    none_word[ID_W-1:0] = ID_W'(NONE_ID);
    cand_word = '0;
    cand_word[ID_W-1:0] = hp_id;
    cand_word[ID_W +: SRC_W] = hp_src;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (word)
        WA_W'(W_CTRL):  bus_rdata[0] = ctrl_en;
        WA_W'(W_THR):   bus_rdata[PRIO_W-1:0] = thr_q;
        WA_W'(W_CLAIM): bus_rdata = qualify ? cand_word : none_word;
        WA_W'(W_RUN):   bus_rdata[PRIO_W-1:0] = run_prio;
        WA_W'(W_PEND):  bus_rdata = hp_valid ? cand_word : none_word;
        default:        bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_cif_arb.sv
module irq_cif_arb #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              hp_valid,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic [PRIO_W-1:0] thr_q,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  output logic              qualify,
  output logic              irq
);
  logic irq_d;

  // Both comparisons strict: equal priority neither passes threshold nor preempts.
  assign qualify = ctrl_en && hp_valid && !stack_full &&
                   (hp_prio < thr_q) && (hp_prio < run_prio);

  always_comb irq_d = qualify;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/irq_cif_stack.sv
module irq_cif_stack #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop_req,
  input  logic [ID_W-1:0]   pop_id,
  output logic              pop_hit,
  output logic              full,
  output logic [CNT_W-1:0]  cnt,
  output logic [PRIO_W-1:0] run_prio
);
  logic [ID_W-1:0]   ent_id   [DEPTH];
  logic [PRIO_W-1:0] ent_prio [DEPTH];
  logic [ID_W-1:0]   nxt_id   [DEPTH];
  logic [PRIO_W-1:0] nxt_prio [DEPTH];
  logic [CNT_W-1:0]  cnt_d;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit_any;
  logic              ld;

  assign full = (cnt == CNT_W'(DEPTH));
  assign run_prio = (cnt == '0) ? '1 : ent_prio[IDX_W'(cnt - 1'b1)];

  // Locate the in-service entry named by a completion (identifiers are unique).
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit_any && (CNT_W'(i) < cnt) && (ent_id[i] == pop_id)) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign pop_hit = pop_req && hit_any;
  assign ld = push || pop_hit;

  // Removal compacts entries above the hit down by one; push appends at cnt.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic shift;
    assign shift = pop_hit && (IDX_W'(g) >= hit_idx);
    always_comb begin
      nxt_id[g]   = ent_id[g];
      nxt_prio[g] = ent_prio[g];
      if (push && (CNT_W'(g) == cnt)) begin
        nxt_id[g]   = push_id;
        nxt_prio[g] = push_prio;
      end else if (shift) begin
        if (g + 1 < DEPTH) begin
          nxt_id[g]   = ent_id[(g + 1) % DEPTH];
          nxt_prio[g] = ent_prio[(g + 1) % DEPTH];
        end else begin
          nxt_id[g]   = '0;
          nxt_prio[g] = '1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_id[g]   <= '0;
        ent_prio[g] <= '1;
      end else if (ld) begin
        ent_id[g]   <= nxt_id[g];
        ent_prio[g] <= nxt_prio[g];
      end
    end
  end

  always_comb begin
    cnt_d = cnt;
    if (push && !full)  cnt_d = cnt + 1'b1;
    else if (pop_hit)   cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= cnt_d;
  end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_valid,
  input  logic [ID_W-1:0]   hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic [SRC_W-1:0]  hp_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              claim_stb,
  output logic [ID_W-1:0]   claim_id,
  output logic              done_stb,
  output logic [ID_W-1:0]   done_id
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              ctrl_en;
  logic [PRIO_W-1:0] thr_q;
  logic              claim_rd, done_wr;
  logic [ID_W-1:0]   done_wid;
  logic              qualify;
  logic              stack_full;
  logic              pop_hit;
  logic [CNT_W-1:0]  act_cnt;
  logic [PRIO_W-1:0] run_prio;

  irq_cif_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .qualify(qualify), .hp_valid(hp_valid), .hp_id(hp_id), .hp_src(hp_src),
    .run_prio(run_prio), .ctrl_en(ctrl_en), .thr_q(thr_q),
    .claim_rd(claim_rd), .done_wr(done_wr), .done_wid(done_wid)
  );

  irq_cif_arb #(.PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .hp_valid(hp_valid),
    .hp_prio(hp_prio), .thr_q(thr_q), .run_prio(run_prio),
    .stack_full(stack_full), .qualify(qualify), .irq(irq)
  );

  assign claim_stb = claim_rd && qualify;
  assign claim_id  = hp_id;

  irq_cif_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(claim_stb), .push_id(hp_id), .push_prio(hp_prio),
    .pop_req(done_wr), .pop_id(done_wid), .pop_hit(pop_hit),
    .full(stack_full), .cnt(act_cnt), .run_prio(run_prio)
  );

  assign done_stb = pop_hit;
  assign done_id  = done_wid;
endmodule

// File: rtl/irq_cif_chk.sv
module irq_cif_chk #(
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ctrl_en,
  input logic              claim_stb,
  input logic              done_stb,
  input logic              hp_valid,
  input logic [PRIO_W-1:0] hp_prio,
  input logic [PRIO_W-1:0] thr_q,
  input logic [PRIO_W-1:0] run_prio,
  input logic [CNT_W-1:0]  act_cnt
);
  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_en));
  // R3
  claim_below_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> (hp_valid && hp_prio < thr_q));
  // R4
  claim_preempts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> (hp_prio < run_prio));
  // R5
  claim_sets_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |=> (run_prio == $past(hp_prio)));
  // R7
  done_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> (act_cnt == $past(act_cnt) - 1'b1));
  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= CNT_W'(DEPTH));
  // R7
  idle_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cnt == '0) |-> (run_prio == '1));
endmodule

bind irq_cpu_if irq_cif_chk #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ctrl_en(ctrl_en),
  .claim_stb(claim_stb), .done_stb(done_stb), .hp_valid(hp_valid),
  .hp_prio(hp_prio), .thr_q(thr_q), .run_prio(run_prio), .act_cnt(act_cnt)
);

// File: tb/sim_irq_cpu_if.sv
module sim_irq_cpu_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hp_valid;
  logic [9:0]  hp_id;
  logic [7:0]  hp_prio;
  logic [1:0]  hp_src;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, claim_stb, done_stb;
  logic [9:0]  claim_id, done_id;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_cpu_if u0 (
    .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id),
    .hp_prio(hp_prio), .hp_src(hp_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .claim_stb(claim_stb), .claim_id(claim_id),
    .done_stb(done_stb), .done_id(done_id)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, output logic stb);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    #1 stb = done_stb;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d, output logic stb);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    #1 d = int'(bus_rdata); stb = claim_stb;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic cand(input bit v, input int id, input int pr, input int src);
    hp_valid = v; hp_id = 10'(id); hp_prio = 8'(pr); hp_src = 2'(src);
  endtask

  task automatic t_reset;
    int d; logic s;
    check("R1 irq", int'(irq), 0);
    rd(12'h00, d, s); check("R1 enable", d, 0);
    rd(12'h04, d, s); check("R1 threshold", d, 0);
    rd(12'h14, d, s); check("R1 running", d, 255);
    cand(1, 5, 1, 0);
    rd(12'h0C, d, s); check("R1 claim", d, 1023); check("R1 strobe", int'(s), 0);
  endtask

  task automatic t_enable;
    int d; logic s;
    wr(12'h04, 32'hF0, s);
    rd(12'h04, d, s); check("R1 threshold readback", d, 240);
    cand(1, 40, 8'h20, 1);
    cyc(2); check("R2 irq low while disabled", int'(irq), 0);
    rd(12'h0C, d, s); check("R2 claim disabled", d, 1023); check("R2 strobe", int'(s), 0);
    wr(12'h00, 1, s);
    rd(12'h00, d, s); check("R1 enable readback", d, 1);
    cyc(1); check("R12 irq after enable", int'(irq), 1);
  endtask

  task automatic t_threshold;
    logic s;
    wr(12'h04, 32'h20, s);
    cand(1, 40, 8'h20, 1);
    cyc(2); check("R3 equal threshold", int'(irq), 0);
    cand(1, 40, 8'h1F, 1);
    @(negedge clk); check("R12 one-stage latency", int'(irq), 1);
    cand(1, 40, 8'h21, 1);
    @(negedge clk); check("R12 drop after one stage", int'(irq), 0);
    wr(12'h04, 32'hF0, s);
  endtask

  task automatic t_claim_nest;
    int d; logic s;
    cand(1, 40, 8'h40, 2);
    rd(12'h0C, d, s); check("R5 claim word", d, (2 << 10) | 40); check("R5 strobe", int'(s), 1);
    rd(12'h14, d, s); check("R9 running after claim", d, 8'h40);
    cand(1, 41, 8'h40, 0);
    cyc(2); check("R4 equal no preempt", int'(irq), 0);
    rd(12'h0C, d, s); check("R4 claim refused", d, 1023);
    rd(12'h18, d, s); check("R10 pending view", d, 41);
    cand(1, 41, 8'h30, 3);
    cyc(2); check("R4 preempt", int'(irq), 1);
    rd(12'h0C, d, s); check("R5 nested claim", d, (3 << 10) | 41);
    rd(12'h14, d, s); check("R9 nested running", d, 8'h30);
    cand(0, 0, 0, 0);
    rd(12'h0C, d, s); check("R6 spurious", d, 1023); check("R6 no strobe", int'(s), 0);
    rd(12'h14, d, s); check("R6 running kept", d, 8'h30);
    rd(12'h18, d, s); check("R10 none pending", d, 1023);
  endtask

  task automatic t_done;
    int d; logic s;
    wr(12'h10, 99, s); check("R8 bogus done strobe", int'(s), 0);
    rd(12'h14, d, s); check("R8 running kept", d, 8'h30);
    wr(12'h10, 40, s); check("R7 outer done strobe", int'(s), 1);
    rd(12'h14, d, s); check("R7 running after outer", d, 8'h30);
    wr(12'h10, 40, s); check("R8 repeat done ignored", int'(s), 0);
    wr(12'h10, 41, s); check("R7 inner done strobe", int'(s), 1);
    rd(12'h14, d, s); check("R7 running idle", d, 255);
  endtask

  task automatic t_full;
    int d; logic s;
    for (int k = 0; k < 4; k++) begin
      cand(1, k + 1, 8'h50 - 8'h10 * k, 0);
      rd(12'h0C, d, s); check("R11 fill claim", d, k + 1);
    end
    cand(1, 9, 8'h10, 0);
    cyc(2); check("R11 irq held low when full", int'(irq), 0);
    rd(12'h0C, d, s); check("R11 claim refused when full", d, 1023);
    wr(12'h10, 4, s);
    cyc(1); check("R11 irq after slot frees", int'(irq), 1);
    rd(12'h14, d, s); check("R7 running after pop", d, 8'h30);
    cand(0, 0, 0, 0);
    for (int k = 3; k >= 1; k--) begin
      wr(12'h10, k, s); check("R7 drain", int'(s), 1);
    end
    rd(12'h14, d, s); check("R7 drained running", d, 255);
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    cand(0, 0, 0, 0);
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_enable();
    t_threshold();
    t_claim_nest();
    t_done();
    t_full();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule